// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Sequencer

This block brings up a target FPGA over its slave-serial configuration port. A host requests a load with a one-cycle start strobe. At the same time it gives a flag that says whether the request is a partial reconfiguration, and a timeout for the final polling phase. The sequencer then works through the whole handshake without further help from the host.

The handshake runs in this order. The sequencer pulls the active-low program pin down for a timed pulse and checks that the target's DONE pin is low. It waits a fixed settling interval. It then shifts the image out one byte at a time. The host feeds the image as a byte stream with valid/ready handshaking and an end-of-image marker. The image is never split into blocks, so its length is not limited.

After the image, the sequencer pads with all-ones bytes until DONE rises. It sends one more all-ones byte and reports success. If DONE does not rise in time, it reports a timeout. Result flags stay readable until the next start. A status output mirrors the synchronised DONE level so the host can tell an unconfigured target from a running one.

Top module: `sscfg_loader`

## Requirements
- R1: A start request with `partial_i` high sets `err_code_o` to 3 (rejected). The block stays idle, and the program pin, configuration clock and data line do not move.
- R2: The program pin rests high whenever the block is idle. A load drives it low for at least PULSE_NS nanoseconds, rounded up to whole clock cycles (1000 ns by default, never below 500 ns).
- R3: DONE is sampled right after the program pin is released. If it is high, the load stops with `err_code_o` = 1 (unexpected DONE) and no configuration clock edge is produced.
- R4: At least WAIT_US microseconds of clock cycles pass between the release of the program pin and the first rising edge of the configuration clock.
- R5: Each image byte is sent MSB first, one bit per rising edge of `cclk_o`. `din_o` changes only while `cclk_o` is low, and each half period of `cclk_o` lasts CCLK_HALF clock cycles.
- R6: If DONE is high when the last image byte completes, exactly one byte of 0xFF follows, then `ok_o` is set.
- R7: If DONE is low when the last image byte completes, 0xFF bytes are sent and DONE is checked after each one. Once DONE is seen high, exactly one more 0xFF byte is sent, then `ok_o` is set.
- R8: During padding, the timeout is checked when each 0xFF byte completes. At the first completion where `timeout_i` clock cycles have passed since padding began and DONE is still low, the load ends with `err_code_o` = 2.
- R9: `tgt_cfg_o` is 0 while DONE is low (target in reset) and 1 while DONE is high (state unknown or configured). It follows DONE through a two-stage synchroniser.
- R10: `s_ready_o` is high only during the data phase, while the shifter is idle with `cclk_o` low, and never after the end-of-image byte has been accepted.
- R11: A start strobe that arrives while `busy_o` is high is ignored; the running load completes unchanged.
- R12: `ok_o` and `err_code_o` (0 none, 1 unexpected DONE, 2 timeout, 3 rejected) keep their value until the next accepted start, which clears them. `ok_o` is never set together with a non-zero error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle load request |
| partial_i | input | 1 | Request is a partial reconfiguration (rejected) |
| timeout_i | input | TO_W | Padding-phase timeout in clock cycles |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Image byte is the last of the image |
| s_ready_o | output | 1 | Block accepts an image byte this cycle |
| prog_n_o | output | 1 | Active-low program pin to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| done_i | input | 1 | DONE pin from the target (asynchronous) |
| busy_o | output | 1 | Load sequence in progress |
| ok_o | output | 1 | Last load finished successfully |
| err_code_o | output | 2 | Result code of the last request |
| tgt_cfg_o | output | 1 | Target state: 0 reset, 1 unknown/configured |

## Verification
Several properties are checked on every cycle:
- A rejected request never moves the program pin.
- The program pin is high when idle, and its low pulse is never shorter than the computed length.
- No configuration clock edge comes before the settling interval ends.
- `din_o` is stable while `cclk_o` is high, and ready appears only with `cclk_o` low.
- Success and error are never reported together.

Other behaviour can only be shown by the bench's scenarios. These cover the exact count of trailing 0xFF bytes for DONE rising at different padding depths, MSB-first byte order over random images, and the number of padding bytes before a timeout. They also cover a start ignored mid-load, the unexpected-DONE abort, and the status output following DONE.

// File: rtl/sscfg_pkg.sv
`timescale 1ns/1ps
// Shared types for the slave-serial configuration sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sscfg_pkg;

    // Result code reported to the host
    typedef enum logic [1:0] {
        ERR_NONE       = 2'd0,
        ERR_DONE_EARLY = 2'd1,
        ERR_TIMEOUT    = 2'd2,
        ERR_REJECT     = 2'd3
    } sscfg_err_e;

    // Sequence states of the controller
    typedef enum logic [2:0] {
        S_IDLE,
        S_PULSE,
        S_CHECK,
        S_WAIT,
        S_DATA,
        S_ENDCHK,
        S_POLL,
        S_TAIL
    } sscfg_state_e;

    localparam logic [7:0] PAD_BYTE = 8'hFF;

endpackage

// File: rtl/sscfg_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for the asynchronous DONE pin.
// Assumes: STAGES >= 2; output resets low (target treated as unconfigured).
module sscfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sscfg_timer.sv
`timescale 1ns/1ps
// Loadable down-counter shared by the pulse, settle and timeout phases.
// Assumes: a load overrides counting; expired_o is high while the count is zero.
module sscfg_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    // Load a new interval or count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sscfg_shifter.sv
`timescale 1ns/1ps
// Byte serialiser that produces the configuration clock and data line.
// A byte is shifted MSB first; data moves on the falling clock edge and
// is stable through each rising edge. One byte takes 16*HALF cycles.
// Assumes: load_i is only honoured while idle; data idles high.
module sscfg_shifter #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       idle_o,
    output logic       cclk_o,
    output logic       din_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          cclk_q;
    logic          act_q;
    logic          tick;

    assign tick = (div_q == CW'(HALF - 1));

    // Half-period divider, clock toggle and shift on the falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= 8'hFF;
            cclk_q <= 1'b0;
            act_q  <= 1'b0;
        end else if (load_i && !act_q) begin
            sh_q   <= byte_i;
            act_q  <= 1'b1;
            cclk_q <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
        end else if (act_q) begin
            if (tick) begin
                div_q <= '0;
                if (!cclk_q) begin
                    cclk_q <= 1'b1;
                end else begin
                    cclk_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b1};
                    bit_q  <= bit_q + 1'b1;
                    if (bit_q == 3'd7) act_q <= 1'b0;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign idle_o = !act_q;
    assign cclk_o = cclk_q;
    assign din_o  = sh_q[7];
endmodule

// File: rtl/sscfg_ctrl.sv
`timescale 1ns/1ps
// Sequence controller: program pulse, DONE sanity check, settle wait,
// image streaming, padding with DONE polling, trailing byte, result flags.
// Assumes: done_s_i is already synchronised; the timer and shifter are
// the neighbouring blocks in the top module.
module sscfg_ctrl
    import sscfg_pkg::*;
#(
    parameter int TO_W      = 32,
    parameter int TMR_W     = 32,
    parameter int PULSE_CYC = 200,
    parameter int WAIT_CYC  = 1500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             partial_i,
    input  logic [TO_W-1:0]  timeout_i,
    input  logic             done_s_i,
    input  logic             tmr_expired_i,
    output logic             tmr_load_o,
    output logic [TMR_W-1:0] tmr_val_o,
    input  logic             sh_idle_i,
    output logic             sh_load_o,
    output logic [7:0]       sh_byte_o,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    input  logic             s_last_i,
    output logic             s_ready_o,
    output logic             prog_n_o,
    output logic             busy_o,
    output logic             ok_o,
    output logic [1:0]       err_code_o
);
    sscfg_state_e state_q, state_d;
    sscfg_err_e   err_q;
    logic         ok_q;
    logic         prog_q;
    logic         last_q;
    logic         accept;
    logic         take;

    assign accept = (state_q == S_IDLE) && start_i;
    assign take   = s_ready_o && s_valid_i;

    // Next-state, timer, shifter and stream-ready decode
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        sh_load_o  = 1'b0;
        sh_byte_o  = s_data_i;
        s_ready_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i && !partial_i) begin
                    state_d    = S_PULSE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TMR_W'(PULSE_CYC);
                end
            end
            S_PULSE: begin
                if (tmr_expired_i) state_d = S_CHECK;
            end
            S_CHECK: begin
                if (done_s_i) begin
                    state_d = S_IDLE;
                end else begin
                    state_d    = S_WAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TMR_W'(WAIT_CYC);
                end
            end
            S_WAIT: begin
                if (tmr_expired_i) state_d = S_DATA;
            end
            S_DATA: begin
                s_ready_o = sh_idle_i && !last_q;
                sh_load_o = s_ready_o && s_valid_i;
                if (last_q && sh_idle_i) state_d = S_ENDCHK;
            end
            S_ENDCHK: begin
                sh_load_o = 1'b1;
                sh_byte_o = PAD_BYTE;
                if (done_s_i) begin
                    state_d = S_TAIL;
                end else begin
                    state_d    = S_POLL;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = TMR_W'(timeout_i);
                end
            end
            S_POLL: begin
                if (sh_idle_i) begin
                    if (done_s_i) begin
                        sh_load_o = 1'b1;
                        sh_byte_o = PAD_BYTE;
                        state_d   = S_TAIL;
                    end else if (tmr_expired_i) begin
                        state_d = S_IDLE;
                    end else begin
                        sh_load_o = 1'b1;
                        sh_byte_o = PAD_BYTE;
                    end
                end
            end
            S_TAIL: begin
                if (sh_idle_i) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Program pin: low from an accepted start until the pulse timer ends
    always_ff @(posedge clk) begin
        if (!rst_n)                                   prog_q <= 1'b1;
        else if (accept && !partial_i)                prog_q <= 1'b0;
        else if (state_q == S_PULSE && tmr_expired_i) prog_q <= 1'b1;
    end

    // End-of-image marker seen during the data phase
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= 1'b0;
        else if (accept)            last_q <= 1'b0;
        else if (take && s_last_i)  last_q <= 1'b1;
    end

    // Sticky result flags, cleared by the next accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            err_q <= ERR_NONE;
        end else if (accept) begin
            ok_q  <= 1'b0;
            err_q <= partial_i ? ERR_REJECT : ERR_NONE;
        end else if (state_q == S_CHECK && done_s_i) begin
            err_q <= ERR_DONE_EARLY;
        end else if (state_q == S_POLL && sh_idle_i && !done_s_i && tmr_expired_i) begin
            err_q <= ERR_TIMEOUT;
        end else if (state_q == S_TAIL && sh_idle_i) begin
            ok_q  <= 1'b1;
        end
    end

    assign prog_n_o   = prog_q;
    assign busy_o     = (state_q != S_IDLE);
    assign ok_o       = ok_q;
    assign err_code_o = err_q;
endmodule

// File: rtl/sscfg_loader.sv
`timescale 1ns/1ps
// Top of the slave-serial configuration sequencer.
// Converts time parameters into cycle counts (rounded so the program
// pulse is never short) and joins synchroniser, timer, shifter and
// controller. Assumes: clk runs at CLK_HZ; done_i is asynchronous.
module sscfg_loader #(
    parameter int CLK_HZ    = 200000000,
    parameter int PULSE_NS  = 1000,
    parameter int WAIT_US   = 7500,
    parameter int CCLK_HALF = 4,
    parameter int TO_W      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            partial_i,
    input  logic [TO_W-1:0] timeout_i,
    input  logic [7:0]      s_data_i,
    input  logic            s_valid_i,
    input  logic            s_last_i,
    output logic            s_ready_o,
    output logic            prog_n_o,
    output logic            cclk_o,
    output logic            din_o,
    input  logic            done_i,
    output logic            busy_o,
    output logic            ok_o,
    output logic [1:0]      err_code_o,
    output logic            tgt_cfg_o
);
    localparam longint NS_PER_S  = 64'd1000000000;
    localparam longint US_PER_S  = 64'd1000000;
    localparam int PULSE_CYC = int'((longint'(CLK_HZ) * longint'(PULSE_NS) + NS_PER_S - 1) / NS_PER_S);
    localparam int WAIT_CYC  = int'((longint'(CLK_HZ) * longint'(WAIT_US) + US_PER_S - 1) / US_PER_S);
    localparam int W_WAIT    = $clog2(WAIT_CYC + 1);
    localparam int W_PULSE   = $clog2(PULSE_CYC + 1);
    localparam int W_TP      = (W_WAIT > W_PULSE) ? W_WAIT : W_PULSE;
    localparam int TMR_W     = (TO_W > W_TP) ? TO_W : W_TP;

    logic             done_s;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sh_load;
    logic [7:0]       sh_byte;
    logic             sh_idle;

    sscfg_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (done_i),
        .q_o   (done_s)
    );

    sscfg_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_expired)
    );

    sscfg_shifter #(.HALF(CCLK_HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .byte_i (sh_byte),
        .idle_o (sh_idle),
        .cclk_o (cclk_o),
        .din_o  (din_o)
    );

    sscfg_ctrl #(
        .TO_W      (TO_W),
        .TMR_W     (TMR_W),
        .PULSE_CYC (PULSE_CYC),
        .WAIT_CYC  (WAIT_CYC)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .partial_i     (partial_i),
        .timeout_i     (timeout_i),
        .done_s_i      (done_s),
        .tmr_expired_i (tmr_expired),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .sh_idle_i     (sh_idle),
        .sh_load_o     (sh_load),
        .sh_byte_o     (sh_byte),
        .s_data_i      (s_data_i),
        .s_valid_i     (s_valid_i),
        .s_last_i      (s_last_i),
        .s_ready_o     (s_ready_o),
        .prog_n_o      (prog_n_o),
        .busy_o        (busy_o),
        .ok_o          (ok_o),
        .err_code_o    (err_code_o)
    );

    assign tgt_cfg_o = done_s;
endmodule

// File: rtl/sscfg_checker.sv
`timescale 1ns/1ps
// Property checker for the configuration sequencer, bound to the top.
// Assumes: PULSE_CYC and WAIT_CYC match the top's derived cycle counts.
module sscfg_checker #(
    parameter int PULSE_CYC = 200,
    parameter int WAIT_CYC  = 1500000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       partial_i,
    input logic       s_ready_o,
    input logic       prog_n_o,
    input logic       cclk_o,
    input logic       din_o,
    input logic       busy_o,
    input logic       ok_o,
    input logic [1:0] err_code_o
);
    logic [31:0] low_cnt_q;
    logic [31:0] rel_cnt_q;

    // Length of the current low phase of the program pin
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_cnt_q <= '0;
        else if (prog_n_o)          low_cnt_q <= '0;
        else if (low_cnt_q != '1)   low_cnt_q <= low_cnt_q + 1'b1;
    end

    // Cycles since the program pin last went high
    always_ff @(posedge clk) begin
        if (!rst_n)                 rel_cnt_q <= '0;
        else if (!prog_n_o)         rel_cnt_q <= '0;
        else if (rel_cnt_q != '1)   rel_cnt_q <= rel_cnt_q + 1'b1;
    end

    AST_REJECT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && partial_i && !busy_o) |=> (err_code_o == 2'd3 && prog_n_o && !busy_o)); // R1

    AST_PROG_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> prog_n_o); // R2

    AST_PROG_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n_o) |-> (low_cnt_q >= 32'(PULSE_CYC))); // R2

    AST_DATA_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> (rel_cnt_q >= 32'(WAIT_CYC))); // R4

    AST_DIN_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && $past(cclk_o)) |-> $stable(din_o)); // R5

    AST_READY_CCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (busy_o && !cclk_o && prog_n_o)); // R10

    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_code_o != 2'd0)); // R12
endmodule

bind sscfg_loader sscfg_checker #(
    .PULSE_CYC (PULSE_CYC),
    .WAIT_CYC  (WAIT_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .partial_i  (partial_i),
    .s_ready_o  (s_ready_o),
    .prog_n_o   (prog_n_o),
    .cclk_o     (cclk_o),
    .din_o      (din_o),
    .busy_o     (busy_o),
    .ok_o       (ok_o),
    .err_code_o (err_code_o)
);

// File: tb/sscfg_loader_bench.sv
`timescale 1ns/1ps
// Self-checking bench: seeded random images and DONE timing plus directed
// corner cases, compared against expectations derived from the requirements.
module sscfg_loader_bench;
    localparam int CLK_HZ    = 200000000;
    localparam int PULSE_NS  = 1000;
    localparam int WAIT_US   = 2;
    localparam int HALF      = 2;
    localparam int TO_W      = 16;
    localparam int PULSE_MIN = 200;
    localparam int WAIT_MIN  = 400;
    localparam int BYTE_CYC  = 16 * HALF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            partial_i = 1'b0;
    logic [TO_W-1:0] timeout_i = '0;
    logic [7:0]      s_data_i = '0;
    logic            s_valid_i = 1'b0;
    logic            s_last_i = 1'b0;
    logic            s_ready_o, prog_n_o, cclk_o, din_o, busy_o, ok_o, tgt_cfg_o;
    logic [1:0]      err_code_o;
    logic            done_force = 1'b0;
    logic            done_hit = 1'b0;
    logic            done_i;

    assign done_i = done_force | done_hit;

    sscfg_loader #(
        .CLK_HZ(CLK_HZ), .PULSE_NS(PULSE_NS), .WAIT_US(WAIT_US),
        .CCLK_HALF(HALF), .TO_W(TO_W)
    ) u_sscfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .timeout_i(timeout_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
        .s_last_i(s_last_i), .s_ready_o(s_ready_o), .prog_n_o(prog_n_o),
        .cclk_o(cclk_o), .din_o(din_o), .done_i(done_i), .busy_o(busy_o),
        .ok_o(ok_o), .err_code_o(err_code_o), .tgt_cfg_o(tgt_cfg_o)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // Pin monitor state (written only by the monitor)
    logic bitmem [0:8191];
    int   bitcnt = 0;
    int   prog_falls = 0;
    int   low_run = 0, last_low = 0;
    int   gap = 0, last_gap = 0;
    bit   gap_on = 0;
    int   din_viol = 0, rdy_viol = 0;
    logic prev_cclk = 1'b0, prev_din = 1'b1, prev_prog = 1'b1;
    // DONE arming (written only by the stimulus)
    bit   arm_en = 0;
    int   arm_tgt = 0;

    // Monitor the target-side pins between clock edges
    always @(negedge clk) begin
        if (cclk_o && !prev_cclk) begin
            if (bitcnt < 8192) bitmem[bitcnt] = din_o;
            bitcnt = bitcnt + 1;
            if (gap_on) begin last_gap = gap; gap_on = 0; end
        end
        if (cclk_o && prev_cclk && din_o != prev_din) din_viol = din_viol + 1;
        if (s_ready_o && cclk_o) rdy_viol = rdy_viol + 1;
        if (!prog_n_o) begin
            if (prev_prog) prog_falls = prog_falls + 1;
            low_run = low_run + 1;
            gap_on = 0;
        end else if (!prev_prog) begin
            last_low = low_run; low_run = 0; gap_on = 1; gap = 0;
        end else if (gap_on) begin
            gap = gap + 1;
        end
        if (!arm_en) done_hit = 1'b0;
        else if (bitcnt == arm_tgt) done_hit = 1'b1;
        prev_cclk = cclk_o; prev_din = din_o; prev_prog = prog_n_o;
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse_start(input bit partial);
        start_i = 1'b1; partial_i = partial;
        step(1);
        start_i = 1'b0; partial_i = 1'b0;
    endtask

    task automatic wait_idle();
        int lim = 20000;
        while (busy_o && lim > 0) begin step(1); lim--; end
        chk(lim > 0, "R12", "load finished", busy_o, 0);
        step(3);
    endtask

    function automatic int pad_bytes_at_least(input int t);
        // R8: completed padding bytes must cover the timeout window
        return (t + BYTE_CYC) / (BYTE_CYC + 1);
    endfunction

    // Run one load: n bytes, DONE rises in pad byte k (k<0: never), poke: stray start
    task automatic run_load(input int n, input int k, input int tmo, input bit poke);
        logic [7:0] img [0:15];
        int base, falls0, pads, bad_bits, bad_pad;
        for (int i = 0; i < n; i++) img[i] = 8'($urandom);
        timeout_i = TO_W'(tmo);
        done_force = 1'b0;
        step(2);
        base = bitcnt; falls0 = prog_falls;
        arm_tgt = base + 8 * n + 8 * (k - 1) + 1;
        arm_en = (k >= 0);
        pulse_start(1'b0);
        if (poke) begin
            step(50);
            pulse_start(1'b1);
        end
        for (int i = 0; i < n; i++) begin
            s_data_i = img[i]; s_valid_i = 1'b1; s_last_i = (i == n - 1);
            begin
                int lim = 5000;
                while (!s_ready_o && lim > 0) begin step(1); lim--; end
            end
            step(1);
        end
        s_valid_i = 1'b0; s_last_i = 1'b0;
        wait_idle();
        bad_bits = 0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++)
                if (bitmem[base + 8 * i + b] !== img[i][7 - b]) bad_bits++;
        pads = (bitcnt - base - 8 * n) / 8;
        bad_pad = 0;
        for (int j = base + 8 * n; j < bitcnt; j++) if (bitmem[j] !== 1'b1) bad_pad++;
        chk(bad_bits == 0, "R5", "image bits MSB first mismatches", bad_bits, 0);
        chk(bad_pad == 0, "R7", "pad bits not all ones", bad_pad, 0);
        chk((bitcnt - base) % 8 == 0, "R5", "whole bytes clocked", bitcnt - base, 8 * (n + pads));
        chk(last_low >= PULSE_MIN, "R2", "program pulse cycles", last_low, PULSE_MIN);
        chk(last_gap >= WAIT_MIN, "R4", "release to first clock cycles", last_gap, WAIT_MIN);
        chk(prog_falls - falls0 == 1, "R11", "program pulses in one load", prog_falls - falls0, 1);
        if (k == 0) begin
            chk(pads == 1, "R6", "trailing bytes with DONE already high", pads, 1);
        end else if (k > 0) begin
            chk(pads == k + 1, "R7", "pad bytes with DONE rising late", pads, k + 1);
        end
        if (k >= 0) begin
            chk(ok_o && err_code_o == 2'd0, "R6", "success flag", {ok_o, err_code_o}, 4);
        end else begin
            chk(!ok_o && err_code_o == 2'd2, "R8", "timeout code", {ok_o, err_code_o}, 2);
            chk(pads >= 1 && pads >= pad_bytes_at_least(tmo) &&
                (pads - 1) * BYTE_CYC <= tmo, "R8", "pad bytes before timeout",
                pads, pad_bytes_at_least(tmo));
        end
        arm_en = 0;
        step(2);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary
    initial begin
        #(150000 * 5);
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        int s, b0, f0;
        s = $urandom(32'h5eed_c0f1);
        step(4);
        chk(prog_n_o && !cclk_o && !busy_o, "R2", "reset pins", {prog_n_o, cclk_o, busy_o}, 4);
        chk(!ok_o && err_code_o == 2'd0 && !s_ready_o, "R12", "reset flags",
            {ok_o, err_code_o, s_ready_o}, 0);
        rst_n = 1'b1;
        step(3);
        chk(tgt_cfg_o == 1'b0, "R9", "status with DONE low", tgt_cfg_o, 0);

        // R1: partial request rejected, no pin movement
        b0 = bitcnt; f0 = prog_falls;
        pulse_start(1'b1);
        step(5);
        chk(err_code_o == 2'd3 && !busy_o, "R1", "reject code", err_code_o, 3);
        chk(prog_falls == f0 && bitcnt == b0 && prog_n_o, "R1", "pins untouched",
            prog_falls - f0 + bitcnt - b0, 0);

        // R3: DONE high after the pulse
        done_force = 1'b1;
        step(3);
        chk(tgt_cfg_o == 1'b1, "R9", "status with DONE high", tgt_cfg_o, 1);
        b0 = bitcnt;
        pulse_start(1'b0);
        chk(err_code_o == 2'd0, "R12", "start clears reject code", err_code_o, 0);
        wait_idle();
        chk(err_code_o == 2'd1 && !ok_o, "R3", "unexpected DONE code", err_code_o, 1);
        chk(bitcnt == b0, "R3", "no clock after abort", bitcnt - b0, 0);
        chk(prog_n_o, "R2", "pin high after abort", prog_n_o, 1);
        done_force = 1'b0;
        step(3);
        chk(tgt_cfg_o == 1'b0, "R9", "status back to reset", tgt_cfg_o, 0);

        // Directed: one byte, DONE already high at the end (R6)
        run_load(1, 0, 1000, 0);
        step(20);
        chk(ok_o && err_code_o == 2'd0, "R12", "success held", {ok_o, err_code_o}, 4);
        // R12: next start clears success
        pulse_start(1'b1);
        chk(!ok_o && err_code_o == 2'd3, "R12", "start clears success", {ok_o, err_code_o}, 3);

        // Random images and DONE depths (R5, R6, R7)
        for (int r = 0; r < 6; r++) run_load(1 + int'($urandom % 6), int'($urandom % 4), 5000, 0);

        // R11: stray start with partial during a load is ignored
        run_load(3, 1, 5000, 1);

        // R8: timeouts, including zero
        run_load(2, -1, 0, 0);
        run_load(2, -1, 50, 0);
        run_load(1, -1, 200 + int'($urandom % 100), 0);

        chk(din_viol == 0, "R5", "data moves while clock high", din_viol, 0);
        chk(rdy_viol == 0, "R10", "ready while clock high", rdy_viol, 0);
        finish_up();
    end
endmodule